// File: doc/BRIEF.md
# Rotating Multi-Code Check Generator and Checker

This block protects short messages that are sent several times over an unreliable path. Every copy of a message carries one check byte, but the function that produces that byte changes from copy to copy according to a small programmable rotation table. Four functions are available: two 8-bit CRCs with different generators and two nibble-based arithmetic sums (one reduced modulo 15, one modulo 13). Because each function is blind to a different set of error patterns, a fault that corrupts every copy in the same way is far less likely to slip through all of them.

The transmit half takes a payload plus the copy number chosen by the sender and returns the payload with the matching check byte and the function code it used. The receive half tracks the copy position inside the current message itself, recomputes the check byte with the function for that position, pulses a per-copy failure, and keeps a sticky error that stays set once any copy of the message has failed. A message-start input opens a new message; a last-copy marker produces a one-cycle message verdict.

Top module: `rmc_codec`

## Requirements
- R1: Function code 0 is an 8-bit CRC with generator polynomial low byte 0x1D (x^8+x^4+x^3+x^2+1), all-zero start value, payload shifted in most significant bit first, no final inversion.
- R2: Function code 1 is the same CRC structure with generator low byte 0x07 (x^8+x^2+x+1).
- R3: Function code 2 splits the payload into nibbles, most significant first, and keeps two sums A and B starting at 0; per nibble A=(A+n) mod 15 then B=(B+A) mod 15; the check byte is B in bits 7:4 and A in bits 3:0.
- R4: Function code 3 is the same nibble scheme reduced modulo 13, with A starting at 1 and B at 0, check byte {B,A}.
- R5: The transmit side uses rotation-table entry (tx_copy_idx mod ROT_N), entry k occupying rot_tbl bits [2k+1:2k]; one cycle after tx_valid it presents tx_out_valid, the unchanged payload, the check byte and the code used.
- R6: The receive side evaluates copy number s of a message with table entry s mod ROT_N, starting at entry 0 and advancing by one per received copy; rx_copy_fail pulses one cycle after rx_valid exactly when the recomputed byte differs from rx_check.
- R7: rx_err rises in the cycle rx_copy_fail is first reported and stays high through later passing copies and idle cycles until a message start.
- R8: rx_msg_start clears rx_err and restarts the copy position at entry 0; when it coincides with rx_valid, that copy is copy 0 of the new message and only its own result feeds the new rx_err.
- R9: A copy with rx_last produces rx_msg_done one cycle later, with rx_msg_fail high exactly when any copy of the message, the last one included, failed.
- R10: After reset every output is zero.
- R11: When every copy of a message suffers the same corruption, rx_msg_fail is set if and only if at least one of the functions selected for those copies detects that corruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rot_tbl | input | 2*ROT_N | Rotation table, two bits per entry |
| tx_valid | input | 1 | Transmit request |
| tx_copy_idx | input | IDX_W | Copy number of the transmitted copy |
| tx_payload | input | PAYLOAD_W | Payload to protect |
| tx_out_valid | output | 1 | Protected copy available |
| tx_out_payload | output | PAYLOAD_W | Payload of the protected copy |
| tx_out_check | output | 8 | Check byte of the protected copy |
| tx_out_code | output | 2 | Function code used for the copy |
| rx_msg_start | input | 1 | Opens a new message |
| rx_valid | input | 1 | Received copy present |
| rx_last | input | 1 | Received copy is the final one of its message |
| rx_payload | input | PAYLOAD_W | Received payload |
| rx_check | input | 8 | Received check byte |
| rx_copy_fail | output | 1 | Pulse: last received copy failed |
| rx_err | output | 1 | Sticky: a copy of the current message failed |
| rx_msg_done | output | 1 | Pulse: message verdict available |
| rx_msg_fail | output | 1 | Verdict: message detected as corrupted |

## Verification
The bench builds the block with a 32-bit payload, a four-entry rotation table and a 4-bit copy index. Four entries let one table hold every function code at once, so copy numbers past the table length show the wrap on both halves, and a 32-bit payload keeps hand-derived check bytes (single low bit, all zeros) easy to state. It also reprograms the table between messages to contrast a single-function rotation, which misses a nibble change from 0 to 15 under the modulo-15 sum, with a mixed rotation that catches the same repeated corruption.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

    localparam int MAX_W   = 96;
    localparam int MAX_NIB = MAX_W / 4;

    typedef logic [MAX_W-1:0] wide_t;

    typedef enum logic [1:0] {
        CODE_CRC8  = 2'd0,
        CODE_FCRC8 = 2'd1,
        CODE_FLT8  = 2'd2,
        CODE_ADL8  = 2'd3
    } code_e;

    localparam logic [7:0] POLY_CRC8  = 8'h1D;
    localparam logic [7:0] POLY_FCRC8 = 8'h07;

    typedef struct packed {
        logic       vld;
        code_e      code;
        logic [7:0] chk;
    } tx_meta_t;

    typedef struct packed {
        logic copy_fail;
        logic done;
        logic msg_fail;
    } rx_evt_t;

    // Bitwise CRC, MSB first. Leading zeros of a zero-extended payload
    // leave a zero register untouched, so the full width can be walked.
    function automatic logic [7:0] crc_calc(input wide_t d, input logic [7:0] poly);
        logic [7:0] r;
        logic       fb;
        r = 8'h00;
        for (int i = MAX_W - 1; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

    // Two running nibble sums; only the lowest nnib nibbles take part.
    function automatic logic [7:0] sum_calc(input wide_t d, input int nnib, input logic mod13);
        int a;
        int b;
        int m;
        m = mod13 ? 13 : 15;
        a = mod13 ? 1 : 0;
        b = 0;
        for (int i = MAX_NIB - 1; i >= 0; i--) begin
            if (i < nnib) begin
                a = (a + int'(d[4*i +: 4])) % m;
                b = (b + a) % m;
            end
        end
        return {b[3:0], a[3:0]};
    endfunction

    function automatic logic [7:0] check_calc(input code_e code, input wide_t d, input int nnib);
        logic [7:0] c;
        case (code)
            CODE_CRC8:  c = crc_calc(d, POLY_CRC8);
            CODE_FCRC8: c = crc_calc(d, POLY_FCRC8);
            CODE_FLT8:  c = sum_calc(d, nnib, 1'b0);
            default:    c = sum_calc(d, nnib, 1'b1);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rmc_check_calc.sv
module rmc_check_calc
    import rmc_pkg::*;
#(
    parameter int PAYLOAD_W = 32
) (
    input  code_e                code,
    input  logic [PAYLOAD_W-1:0] data,
    output logic [7:0]           chk
);
    localparam int NNIB = PAYLOAD_W / 4;

    wide_t wide;

    always_comb begin
        wide = '0;
        wide[PAYLOAD_W-1:0] = data;
        chk = check_calc(code, wide, NNIB);
    end

endmodule

// File: rtl/rmc_rot_sel.sv
module rmc_rot_sel
    import rmc_pkg::*;
#(
    parameter int ROT_N  = 4,
    parameter int SLOT_W = 2
) (
    input  logic [2*ROT_N-1:0] rot_tbl,
    input  logic [SLOT_W-1:0]  slot,
    output code_e              code
);
    logic [1:0] entry [ROT_N];

    for (genvar k = 0; k < ROT_N; k++) begin : g_entry
        assign entry[k] = rot_tbl[2*k +: 2];
    end

    always_comb begin
        code = CODE_CRC8;
        for (int k = 0; k < ROT_N; k++) begin
            if (int'(slot) == k) code = code_e'(entry[k]);
        end
    end

endmodule

// File: rtl/rmc_tx.sv
module rmc_tx
    import rmc_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int ROT_N     = 4,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*ROT_N-1:0]   rot_tbl,
    input  logic                 tx_valid,
    input  logic [IDX_W-1:0]     tx_copy_idx,
    input  logic [PAYLOAD_W-1:0] tx_payload,
    output logic                 tx_out_valid,
    output logic [PAYLOAD_W-1:0] tx_out_payload,
    output logic [7:0]           tx_out_check,
    output logic [1:0]           tx_out_code
);
    localparam int SLOT_W = (ROT_N > 1) ? $clog2(ROT_N) : 1;

    logic [SLOT_W-1:0] slot;
    code_e             code;
    logic [7:0]        chk;
    tx_meta_t          meta_q;
    logic [PAYLOAD_W-1:0] pay_q;

    assign slot = SLOT_W'(int'(tx_copy_idx) % ROT_N);

    rmc_rot_sel #(.ROT_N(ROT_N), .SLOT_W(SLOT_W)) u_sel (
        .rot_tbl (rot_tbl),
        .slot    (slot),
        .code    (code)
    );

    rmc_check_calc #(.PAYLOAD_W(PAYLOAD_W)) u_calc (
        .code (code),
        .data (tx_payload),
        .chk  (chk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            pay_q  <= '0;
        end else begin
            meta_q.vld <= tx_valid;
            if (tx_valid) begin
                meta_q.code <= code;
                meta_q.chk  <= chk;
                pay_q       <= tx_payload;
            end
        end
    end

    assign tx_out_valid   = meta_q.vld;
    assign tx_out_payload = pay_q;
    assign tx_out_check   = meta_q.chk;
    assign tx_out_code    = meta_q.code;

    // R5
    tx_latency_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_out_valid);

    // R5
    tx_payload_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> tx_out_payload == $past(tx_payload));

endmodule

// File: rtl/rmc_rx.sv
module rmc_rx
    import rmc_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int ROT_N     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*ROT_N-1:0]   rot_tbl,
    input  logic                 rx_msg_start,
    input  logic                 rx_valid,
    input  logic                 rx_last,
    input  logic [PAYLOAD_W-1:0] rx_payload,
    input  logic [7:0]           rx_check,
    output logic                 rx_copy_fail,
    output logic                 rx_err,
    output logic                 rx_msg_done,
    output logic                 rx_msg_fail
);
    localparam int SLOT_W = (ROT_N > 1) ? $clog2(ROT_N) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(ROT_N - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] slot_eff;
    logic [SLOT_W-1:0] slot_nxt;
    logic              sticky_q;
    logic              sticky_base;
    logic              mismatch;
    code_e             code;
    logic [7:0]        chk;
    rx_evt_t           evt_q;

    assign slot_eff    = rx_msg_start ? '0 : slot_q;
    assign slot_nxt    = (slot_eff == SLOT_LAST) ? '0 : slot_eff + 1'b1;
    assign sticky_base = rx_msg_start ? 1'b0 : sticky_q;

    rmc_rot_sel #(.ROT_N(ROT_N), .SLOT_W(SLOT_W)) u_sel (
        .rot_tbl (rot_tbl),
        .slot    (slot_eff),
        .code    (code)
    );

    rmc_check_calc #(.PAYLOAD_W(PAYLOAD_W)) u_calc (
        .code (code),
        .data (rx_payload),
        .chk  (chk)
    );

    assign mismatch = rx_valid && (chk != rx_check);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            sticky_q <= 1'b0;
            evt_q    <= '0;
        end else begin
            if (rx_valid)          slot_q <= slot_nxt;
            else if (rx_msg_start) slot_q <= '0;
            sticky_q       <= sticky_base | mismatch;
            evt_q.copy_fail <= mismatch;
            evt_q.done      <= rx_valid && rx_last;
            evt_q.msg_fail  <= (rx_valid && rx_last) ? (sticky_base | mismatch) : 1'b0;
        end
    end

    assign rx_copy_fail = evt_q.copy_fail;
    assign rx_err       = sticky_q;
    assign rx_msg_done  = evt_q.done;
    assign rx_msg_fail  = evt_q.msg_fail;

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_err) |-> $past(rx_msg_start));

    // R7
    fail_sets_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        rx_copy_fail |-> rx_err);

    // R9
    done_follows_last_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_last) |=> rx_msg_done);

    // R9
    verdict_match_chk: assert property (@(posedge clk) disable iff (rst)
        rx_msg_done |-> (rx_msg_fail == rx_err));

    // R9
    verdict_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        rx_msg_fail |-> rx_msg_done);

endmodule

// File: rtl/rmc_codec.sv
module rmc_codec
    import rmc_pkg::*;
#(
    parameter int PAYLOAD_W = 32,
    parameter int ROT_N     = 4,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*ROT_N-1:0]   rot_tbl,
    input  logic                 tx_valid,
    input  logic [IDX_W-1:0]     tx_copy_idx,
    input  logic [PAYLOAD_W-1:0] tx_payload,
    output logic                 tx_out_valid,
    output logic [PAYLOAD_W-1:0] tx_out_payload,
    output logic [7:0]           tx_out_check,
    output logic [1:0]           tx_out_code,
    input  logic                 rx_msg_start,
    input  logic                 rx_valid,
    input  logic                 rx_last,
    input  logic [PAYLOAD_W-1:0] rx_payload,
    input  logic [7:0]           rx_check,
    output logic                 rx_copy_fail,
    output logic                 rx_err,
    output logic                 rx_msg_done,
    output logic                 rx_msg_fail
);

    rmc_tx #(.PAYLOAD_W(PAYLOAD_W), .ROT_N(ROT_N), .IDX_W(IDX_W)) u_tx (
        .clk            (clk),
        .rst            (rst),
        .rot_tbl        (rot_tbl),
        .tx_valid       (tx_valid),
        .tx_copy_idx    (tx_copy_idx),
        .tx_payload     (tx_payload),
        .tx_out_valid   (tx_out_valid),
        .tx_out_payload (tx_out_payload),
        .tx_out_check   (tx_out_check),
        .tx_out_code    (tx_out_code)
    );

    rmc_rx #(.PAYLOAD_W(PAYLOAD_W), .ROT_N(ROT_N)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .rot_tbl      (rot_tbl),
        .rx_msg_start (rx_msg_start),
        .rx_valid     (rx_valid),
        .rx_last      (rx_last),
        .rx_payload   (rx_payload),
        .rx_check     (rx_check),
        .rx_copy_fail (rx_copy_fail),
        .rx_err       (rx_err),
        .rx_msg_done  (rx_msg_done),
        .rx_msg_fail  (rx_msg_fail)
    );

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !tx_out_valid && !rx_copy_fail && !rx_err && !rx_msg_done);

endmodule

// File: tb/rmc_codec_bench.sv
`timescale 1ns/1ps
module rmc_codec_bench;

    localparam int PW = 32;
    localparam int RN = 4;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2*RN-1:0] rot_tbl = '0;
    logic          tx_valid = 1'b0;
    logic [IW-1:0] tx_copy_idx = '0;
    logic [PW-1:0] tx_payload = '0;
    logic          tx_out_valid;
    logic [PW-1:0] tx_out_payload;
    logic [7:0]    tx_out_check;
    logic [1:0]    tx_out_code;
    logic          rx_msg_start = 1'b0;
    logic          rx_valid = 1'b0;
    logic          rx_last = 1'b0;
    logic [PW-1:0] rx_payload = '0;
    logic [7:0]    rx_check = '0;
    logic          rx_copy_fail;
    logic          rx_err;
    logic          rx_msg_done;
    logic          rx_msg_fail;

    int checks = 0;
    int failures = 0;
    logic [1:0] btbl [RN];
    int  bslot = 0;
    logic bsticky = 1'b0;

    always #2.5 clk = ~clk;

    rmc_codec #(.PAYLOAD_W(PW), .ROT_N(RN), .IDX_W(IW)) u_rmc_codec (
        .clk(clk), .rst(rst), .rot_tbl(rot_tbl),
        .tx_valid(tx_valid), .tx_copy_idx(tx_copy_idx), .tx_payload(tx_payload),
        .tx_out_valid(tx_out_valid), .tx_out_payload(tx_out_payload),
        .tx_out_check(tx_out_check), .tx_out_code(tx_out_code),
        .rx_msg_start(rx_msg_start), .rx_valid(rx_valid), .rx_last(rx_last),
        .rx_payload(rx_payload), .rx_check(rx_check),
        .rx_copy_fail(rx_copy_fail), .rx_err(rx_err),
        .rx_msg_done(rx_msg_done), .rx_msg_fail(rx_msg_fail)
    );

    // Reference model written from the requirements
    function automatic logic [7:0] m_crc(input logic [PW-1:0] d, input logic [7:0] p);
        logic [7:0] r = 8'h00;
        for (int i = PW - 1; i >= 0; i--) begin
            if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ p;
            else             r = {r[6:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] m_sum(input logic [PW-1:0] d, input int m, input int a0);
        int a = a0;
        int b = 0;
        for (int i = PW/4 - 1; i >= 0; i--) begin
            a = (a + int'(d[4*i +: 4])) % m;
            b = (b + a) % m;
        end
        return {b[3:0], a[3:0]};
    endfunction

    function automatic logic [7:0] m_chk(input logic [1:0] c, input logic [PW-1:0] d);
        case (c)
            2'd0:    return m_crc(d, 8'h1D);
            2'd1:    return m_crc(d, 8'h07);
            2'd2:    return m_sum(d, 15, 0);
            default: return m_sum(d, 13, 1);
        endcase
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_tbl(input logic [1:0] e0, input logic [1:0] e1, input logic [1:0] e2, input logic [1:0] e3);
        btbl[0] = e0; btbl[1] = e1; btbl[2] = e2; btbl[3] = e3;
        rot_tbl = {e3, e2, e1, e0};
    endtask

    task automatic tx_send(input int idx, input logic [PW-1:0] pl, input logic [7:0] exp_chk, input string req);
        logic [1:0] ec;
        ec = btbl[idx % RN];
        @(negedge clk);
        tx_valid = 1'b1; tx_copy_idx = IW'(idx); tx_payload = pl;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        @(negedge clk);
        check(tx_out_valid == 1'b1, {req, " tx valid"}, 32'(tx_out_valid), 32'd1);
        check(tx_out_code == ec, {req, " tx code"}, 32'(tx_out_code), 32'(ec));
        check(tx_out_check == exp_chk, {req, " tx check"}, 32'(tx_out_check), 32'(exp_chk));
        check(tx_out_payload == pl, {req, " tx payload"}, tx_out_payload, pl);
    endtask

    task automatic rx_copy(input logic st, input logic lst, input logic [PW-1:0] pl,
                           input logic [7:0] ck, input string req);
        int s;
        logic ef;
        s = st ? 0 : bslot;
        ef = (m_chk(btbl[s], pl) != ck);
        bsticky = (st ? 1'b0 : bsticky) | ef;
        bslot = (s + 1) % RN;
        @(negedge clk);
        rx_msg_start = st; rx_valid = 1'b1; rx_last = lst; rx_payload = pl; rx_check = ck;
        @(posedge clk); #1;
        rx_msg_start = 1'b0; rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
        check(rx_copy_fail == ef, {req, " copy fail"}, 32'(rx_copy_fail), 32'(ef));
        check(rx_err == bsticky, {req, " sticky"}, 32'(rx_err), 32'(bsticky));
        check(rx_msg_done == lst, {req, " done"}, 32'(rx_msg_done), 32'(lst));
        if (lst) check(rx_msg_fail == bsticky, {req, " verdict"}, 32'(rx_msg_fail), 32'(bsticky));
    endtask

    // good copy: check byte made with the function the sender uses for this slot
    function automatic logic [7:0] good_ck(input logic st, input logic [PW-1:0] pl);
        return m_chk(btbl[st ? 0 : bslot], pl);
    endfunction

    task automatic t_reset();
        check(tx_out_valid == 1'b0 && tx_out_check == 8'h00 && tx_out_code == 2'd0 && tx_out_payload == '0,
              "R10 tx outputs", {tx_out_check, 22'd0, tx_out_code}, 32'd0);
        check(rx_copy_fail == 1'b0 && rx_err == 1'b0 && rx_msg_done == 1'b0 && rx_msg_fail == 1'b0,
              "R10 rx outputs", {28'd0, rx_copy_fail, rx_err, rx_msg_done, rx_msg_fail}, 32'd0);
    endtask

    task automatic t_known_values();
        set_tbl(2'd0, 2'd1, 2'd2, 2'd3);
        tx_send(0, 32'h0000_0001, 8'h1D, "R1");
        tx_send(1, 32'h0000_0001, 8'h07, "R2");
        tx_send(2, 32'h0000_0001, 8'h11, "R3");
        tx_send(3, 32'h0000_0000, 8'h81, "R4");
        tx_send(0, 32'hA5C3_0F71, m_chk(2'd0, 32'hA5C3_0F71), "R1 mixed");
        tx_send(1, 32'hFFFF_FFFF, m_chk(2'd1, 32'hFFFF_FFFF), "R2 ones");
        tx_send(2, 32'hFFFF_FFFF, m_chk(2'd2, 32'hFFFF_FFFF), "R3 ones");
        tx_send(3, 32'hDEAD_BEEF, m_chk(2'd3, 32'hDEAD_BEEF), "R4 mixed");
    endtask

    task automatic t_tx_rotation();
        set_tbl(2'd2, 2'd3, 2'd0, 2'd1);
        for (int i = 0; i < 10; i++) begin
            logic [PW-1:0] p;
            p = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0303);
            tx_send(i, p, m_chk(btbl[i % RN], p), "R5 rotation");
        end
    endtask

    task automatic t_rx_clean_wrap();
        set_tbl(2'd3, 2'd0, 2'd3, 2'd0);
        for (int i = 0; i < 6; i++) begin
            logic [PW-1:0] p;
            logic st;
            st = (i == 0);
            p = 32'hCAFE_0000 | 32'(i);
            rx_copy(st, i == 5, p, good_ck(st, p), "R6 clean");
        end
        // mixed table, copies beyond the table length wrap to entry 0
        set_tbl(2'd1, 2'd2, 2'd3, 2'd0);
        for (int i = 0; i < 7; i++) begin
            logic [PW-1:0] p;
            logic st;
            st = (i == 0);
            p = 32'h0BAD_F00D + 32'(i);
            rx_copy(st, i == 6, p, good_ck(st, p), "R6 wrap");
        end
    endtask

    task automatic t_common_error();
        logic [PW-1:0] p;
        logic [PW-1:0] err;
        p   = 32'h1234_5608;
        err = 32'h0000_00F0;
        // modulo-15 sums only: nibble 0 turned to 15 goes unseen
        set_tbl(2'd2, 2'd2, 2'd2, 2'd2);
        check(m_sum(p, 15, 0) == m_sum(p ^ err, 15, 0), "R11 model blind", 32'(m_sum(p ^ err, 15, 0)), 32'(m_sum(p, 15, 0)));
        for (int i = 0; i < 3; i++)
            rx_copy(i == 0, i == 2, p ^ err, m_chk(2'd2, p), "R11 blind rotation");
        check(rx_msg_fail == 1'b0, "R11 undetected", 32'(rx_msg_fail), 32'd0);
        // mixed rotation catches the same repeated fault
        set_tbl(2'd2, 2'd0, 2'd2, 2'd3);
        for (int i = 0; i < 3; i++)
            rx_copy(i == 0, i == 2, p ^ err, m_chk(btbl[i], p), "R11 mixed rotation");
        check(rx_msg_fail == 1'b1, "R11 detected", 32'(rx_msg_fail), 32'd1);
        // another repeated fault pattern across all four functions
        set_tbl(2'd3, 2'd0, 2'd1, 2'd2);
        for (int i = 0; i < 4; i++)
            rx_copy(i == 0, i == 3, 32'h0F0F_1234 ^ 32'h0001_8000, m_chk(btbl[i], 32'h0F0F_1234), "R11 four codes");
    endtask

    task automatic t_sticky_and_boundary();
        logic [PW-1:0] p;
        set_tbl(2'd3, 2'd0, 2'd3, 2'd0);
        p = 32'h7777_1111;
        rx_copy(1'b1, 1'b0, p, good_ck(1'b1, p) ^ 8'h01, "R7 first copy bad");
        rx_copy(1'b0, 1'b0, p, good_ck(1'b0, p), "R7 good after bad");
        repeat (3) @(negedge clk);
        check(rx_err == 1'b1, "R7 hold over idle", 32'(rx_err), 32'd1);
        rx_copy(1'b0, 1'b1, p, good_ck(1'b0, p), "R9 verdict keeps earlier failure");
        // stand-alone start clears sticky and position
        @(negedge clk); rx_msg_start = 1'b1;
        @(posedge clk); #1; rx_msg_start = 1'b0;
        @(negedge clk);
        bsticky = 1'b0; bslot = 0;
        check(rx_err == 1'b0, "R8 start clears sticky", 32'(rx_err), 32'd0);
        rx_copy(1'b0, 1'b0, p, m_chk(btbl[0], p), "R8 position restarted");
        // start in the middle of a message with a copy on the same cycle
        set_tbl(2'd1, 2'd2, 2'd3, 2'd0);
        rx_copy(1'b0, 1'b0, p, 8'h00 ^ ~m_chk(btbl[bslot], p), "R8 fail before restart");
        rx_copy(1'b1, 1'b0, p, m_chk(btbl[0], p), "R8 start with copy");
        check(rx_err == 1'b0, "R8 new message clean", 32'(rx_err), 32'd0);
        rx_copy(1'b0, 1'b1, p, m_chk(btbl[1], p) ^ 8'h80, "R9 last copy fails");
        check(rx_msg_fail == 1'b1, "R9 last copy counted", 32'(rx_msg_fail), 32'd1);
        @(negedge clk);
        check(rx_msg_done == 1'b0, "R9 done is a pulse", 32'(rx_msg_done), 32'd0);
    endtask

    initial begin
        set_tbl(2'd3, 2'd0, 2'd3, 2'd0);
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_known_values();
        t_tx_rotation();
        t_rx_clean_wrap();
        t_common_error();
        t_sticky_and_boundary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule